// File: doc/BRIEF.md
# Two-Channel Timer Interrupt Combiner

This block gathers the event flags of a two-channel timer into one maskable interrupt request per channel. Each channel holds six sticky event flags: four compare/capture match flags, an overflow flag and an underflow flag. The flags are set by one-cycle event strobes from the timer core and are cleared only when software writes them. A per-channel enable register masks the flags, and the channel request is the OR of every flag whose enable is set. The request is not latched. It follows the registers, so withdrawing the last enabled flag or its enable removes a request that was never taken.

Each channel also has a control register that holds a priority level and shows the request as a read-only bit. The block delivers one interrupt when the global interrupt enable is set, a channel requests, and that channel's level is strictly above the current processor priority level. When both channels qualify, the higher level wins. Channel 0 wins a tie. The block reports the winning channel and its level. The counters, compare logic and vector fetch are outside this block.

Register map (`reg_addr` = channel × 4 + offset): offset 0 is status, offset 1 is enable, offset 2 is control, and offset 3 reads 0. Writes are taken on the rising clock edge while `reg_we` is 1. Reads are combinational from `reg_addr`.

Top module: `tmr_irq_combiner`

## Requirements
- R1: A one-cycle strobe sets its status flag at the next clock edge. The status bits are: bit0 match A, bit1 match B, bit2 match C, bit3 match D, bit4 overflow, bit5 underflow. Bits 7:6 read 0.
- R2: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. A flag never clears for any other reason, including delivery of the interrupt.
- R3: If an event strobe and a clearing write to the same flag fall in the same cycle, the flag ends up set.
- R4: The enable register has bit0 to bit3 for matches A to D. Bit4 is one shared enable that gates both the overflow and the underflow flags. Bits 7:5 read 0.
- R5: A channel's request is 1 whenever some status flag and its enable are both 1. It drops to 0 in the cycle after the write that leaves no enabled flag set.
- R6: The request stays 1 while any other enabled flag is still set, even after one flag or one enable is cleared.
- R7: Control bits 2:0 hold the channel priority level and can be read and written. Control bit3 reads the channel request, and writes to bit3 have no effect. Bits 7:4 read 0.
- R8: `irq_out` is 1 only when `gie` is 1, the channel requests, and its level is strictly above `cpu_ipl`. A level of 0 never delivers.
- R9: When both channels qualify, `irq_ch`/`irq_lvl` name the channel with the higher level. On equal levels they name channel 0.
- R10: After reset, every status, enable and control register reads 0 and `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address (channel × 4 + offset) |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ev_match | input | 8 | Match strobes, channel c uses bits 4c+3..4c (A..D) |
| ev_ovf | input | 2 | Overflow strobe per channel |
| ev_udf | input | 2 | Underflow strobe per channel |
| gie | input | 1 | Global interrupt enable |
| cpu_ipl | input | 3 | Current processor priority level |
| irq_req | output | 2 | Request bit per channel |
| irq_out | output | 1 | Interrupt delivered |
| irq_ch | output | 1 | Winning channel |
| irq_lvl | output | 3 | Level of the winning channel |

## Verification
The bench drives a strobe and a clearing write into the same cycle. A design that gives the write priority would lose that event. It clears the overflow enable while only the underflow flag is set, which catches a design that gates underflow with anything other than the shared bit. It clears one of two enabled flags and checks that the request stays up, then clears the last one and checks that the request drops at once. A latched request would stay high, and an AND in place of the OR would drop too early. It tests levels equal to `cpu_ipl`, level 0, and equal levels on both channels, which expose a non-strict compare and a reversed tie-break.

// File: rtl/tic_pkg.sv
package tic_pkg;
   localparam int FLAG_N   = 6;
   localparam int EN_N     = 5;
   localparam int MATCH_N  = 4;
   localparam int F_OVF    = 4;
   localparam int F_UDF    = 5;
   localparam int E_OU     = 4;
   localparam int OFF_STS  = 0;
   localparam int OFF_ENA  = 1;
   localparam int OFF_CTL  = 2;

   typedef logic [FLAG_N-1:0] flags_t;
   typedef logic [EN_N-1:0]   enables_t;
endpackage

// File: rtl/tic_flag_bank.sv
module tic_flag_bank
   import tic_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [FLAG_N-1:0]   wr_mask,
   input  logic [FLAG_N-1:0]   events,
   output flags_t              flags
);
   flags_t flags_q;

   for (genvar b = 0; b < FLAG_N; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags_q[b] <= 1'b0;
         else if (events[b])
            flags_q[b] <= 1'b1;
         else if (wr_en && !wr_mask[b])
            flags_q[b] <= 1'b0;
      end
   end

   assign flags = flags_q;
endmodule

// File: rtl/tic_chan.sv
module tic_chan
   import tic_pkg::*;
#(
   parameter int PRIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_sts,
   input  logic               wr_ena,
   input  logic               wr_ctl,
   input  logic [7:0]         wdata,
   input  logic [MATCH_N-1:0] ev_match,
   input  logic               ev_ovf,
   input  logic               ev_udf,
   output flags_t             sts,
   output enables_t           ena,
   output logic [PRIO_W-1:0]  prio,
   output logic               req
);
   flags_t              ev_vec;
   flags_t              ena_wide;
   enables_t            ena_q;
   logic [PRIO_W-1:0]   prio_q;

   assign ev_vec = {ev_udf, ev_ovf, ev_match};

   tic_flag_bank u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_sts),
      .wr_mask (wdata[FLAG_N-1:0]),
      .events  (ev_vec),
      .flags   (sts)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q  <= '0;
         prio_q <= '0;
      end else begin
         if (wr_ena) ena_q  <= wdata[EN_N-1:0];
         if (wr_ctl) prio_q <= wdata[PRIO_W-1:0];
      end
   end

   always_comb begin
      ena_wide               = '0;
      ena_wide[MATCH_N-1:0]  = ena_q[MATCH_N-1:0];
      ena_wide[F_OVF]        = ena_q[E_OU];
      ena_wide[F_UDF]        = ena_q[E_OU];
   end

   assign req  = |(sts & ena_wide);
   assign ena  = ena_q;
   assign prio = prio_q;
endmodule

// File: rtl/tic_arbiter.sv
module tic_arbiter #(
   parameter int NUM_CH = 2,
   parameter int PRIO_W = 3,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0]        req,
   input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
   input  logic                     gie,
   input  logic [PRIO_W-1:0]        ipl,
   output logic                     valid,
   output logic [CH_W-1:0]          ch,
   output logic [PRIO_W-1:0]        lvl
);
   always_comb begin
      valid = 1'b0;
      ch    = '0;
      lvl   = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (gie && req[i] && prio_flat[i*PRIO_W +: PRIO_W] > ipl &&
             (!valid || prio_flat[i*PRIO_W +: PRIO_W] > lvl)) begin
            valid = 1'b1;
            ch    = CH_W'(i);
            lvl   = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/tmr_irq_combiner.sv
module tmr_irq_combiner
   import tic_pkg::*;
#(
   parameter int NUM_CH  = 2,
   parameter int PRIO_W  = 3,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W = CH_W + 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [7:0]                reg_wdata,
   input  logic                      reg_we,
   output logic [7:0]                reg_rdata,
   input  logic [NUM_CH*MATCH_N-1:0] ev_match,
   input  logic [NUM_CH-1:0]         ev_ovf,
   input  logic [NUM_CH-1:0]         ev_udf,
   input  logic                      gie,
   input  logic [PRIO_W-1:0]         cpu_ipl,
   output logic [NUM_CH-1:0]         irq_req,
   output logic                      irq_out,
   output logic [CH_W-1:0]           irq_ch,
   output logic [PRIO_W-1:0]         irq_lvl
);
   if (NUM_CH < 1)
      $error("tmr_irq_combiner: NUM_CH must be at least 1");
   if (PRIO_W < 1 || PRIO_W > 7)
      $error("tmr_irq_combiner: PRIO_W must lie in 1..7");

   logic [CH_W-1:0]             sel_ch;
   logic [1:0]                  sel_off;
   logic [NUM_CH*FLAG_N-1:0]    sts_flat;
   logic [NUM_CH*EN_N-1:0]      ena_flat;
   logic [NUM_CH*PRIO_W-1:0]    prio_flat;

   assign sel_ch  = reg_addr[ADDR_W-1:2];
   assign sel_off = reg_addr[1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = reg_we && (int'(sel_ch) == c);

      tic_chan #(.PRIO_W(PRIO_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_sts   (hit && sel_off == 2'(OFF_STS)),
         .wr_ena   (hit && sel_off == 2'(OFF_ENA)),
         .wr_ctl   (hit && sel_off == 2'(OFF_CTL)),
         .wdata    (reg_wdata),
         .ev_match (ev_match[c*MATCH_N +: MATCH_N]),
         .ev_ovf   (ev_ovf[c]),
         .ev_udf   (ev_udf[c]),
         .sts      (sts_flat[c*FLAG_N +: FLAG_N]),
         .ena      (ena_flat[c*EN_N +: EN_N]),
         .prio     (prio_flat[c*PRIO_W +: PRIO_W]),
         .req      (irq_req[c])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (int'(sel_ch) == c) begin
            case (sel_off)
               2'(OFF_STS): reg_rdata[FLAG_N-1:0] = sts_flat[c*FLAG_N +: FLAG_N];
               2'(OFF_ENA): reg_rdata[EN_N-1:0]   = ena_flat[c*EN_N +: EN_N];
               2'(OFF_CTL): begin
                  reg_rdata[PRIO_W-1:0] = prio_flat[c*PRIO_W +: PRIO_W];
                  reg_rdata[PRIO_W]     = irq_req[c];
               end
               default: reg_rdata = '0;
            endcase
         end
      end
   end

   tic_arbiter #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_arb (
      .req       (irq_req),
      .prio_flat (prio_flat),
      .gie       (gie),
      .ipl       (cpu_ipl),
      .valid     (irq_out),
      .ch        (irq_ch),
      .lvl       (irq_lvl)
   );
endmodule

// File: rtl/tic_checker.sv
module tic_checker
   import tic_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int PRIO_W = 3,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_we,
   input logic [NUM_CH-1:0]         ev_ovf,
   input logic [NUM_CH-1:0]         ev_udf,
   input logic [NUM_CH*FLAG_N-1:0]  sts_flat,
   input logic [NUM_CH*EN_N-1:0]    ena_flat,
   input logic [NUM_CH-1:0]         irq_req,
   input logic                      irq_out,
   input logic [CH_W-1:0]           irq_ch,
   input logic [PRIO_W-1:0]         irq_lvl,
   input logic                      gie,
   input logic [PRIO_W-1:0]         cpu_ipl
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      // R3
      ovf_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ev_ovf[c] |=> sts_flat[c*FLAG_N + F_OVF]);
      // R2
      flag_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sts_flat[c*FLAG_N + F_UDF]) |-> $past(ev_udf[c]));
      // R4
      shared_enable_udf_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ev_udf[c] && ena_flat[c*EN_N + E_OU] && !reg_we) |=> irq_req[c]);
      // R5
      req_drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(irq_req[c]) |-> $past(reg_we));
   end

   // R8
   deliver_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (gie && irq_lvl > cpu_ipl));
   // R9
   winner_requests_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> irq_req[irq_ch]);
endmodule

bind tmr_irq_combiner tic_checker #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .ev_ovf   (ev_ovf),
   .ev_udf   (ev_udf),
   .sts_flat (sts_flat),
   .ena_flat (ena_flat),
   .irq_req  (irq_req),
   .irq_out  (irq_out),
   .irq_ch   (irq_ch),
   .irq_lvl  (irq_lvl),
   .gie      (gie),
   .cpu_ipl  (cpu_ipl)
);

// File: tb/tmr_irq_combiner_tb.sv
module tmr_irq_combiner_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_rdata;
   logic [7:0] ev_match = '0;
   logic [1:0] ev_ovf = '0;
   logic [1:0] ev_udf = '0;
   logic       gie = 1'b0;
   logic [2:0] cpu_ipl = '0;
   logic [1:0] irq_req;
   logic       irq_out;
   logic [0:0] irq_ch;
   logic [2:0] irq_lvl;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   tmr_irq_combiner dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .ev_match(ev_match),
      .ev_ovf(ev_ovf), .ev_udf(ev_udf), .gie(gie), .cpu_ipl(cpu_ipl),
      .irq_req(irq_req), .irq_out(irq_out), .irq_ch(irq_ch), .irq_lvl(irq_lvl)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_addr = 3'(a); reg_wdata = 8'(d); reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input int a, input int exp);
      reg_addr = 3'(a);
      #1;
      chk(tag, int'(reg_rdata), exp);
   endtask

   task automatic pulse(input logic [7:0] m, input logic [1:0] o, input logic [1:0] u);
      @(negedge clk);
      ev_match = m; ev_ovf = o; ev_udf = u;
      @(negedge clk);
      ev_match = '0; ev_ovf = '0; ev_udf = '0;
   endtask

   task automatic t_reset();
      for (int a = 0; a < 8; a++) rd_chk("R10 reset regs", a, 0);
      chk("R10 reset irq_out", int'(irq_out), 0);
   endtask

   task automatic t_set();
      pulse(8'h01, 2'b00, 2'b00);
      rd_chk("R1 ch0 match A", 0, 8'h01);
      pulse(8'h00, 2'b10, 2'b00);
      rd_chk("R1 ch1 overflow", 4, 8'h10);
      pulse(8'h00, 2'b00, 2'b10);
      rd_chk("R1 ch1 underflow", 4, 8'h30);
      pulse(8'h80, 2'b00, 2'b00);
      rd_chk("R1 ch1 match D", 4, 8'h38);
   endtask

   task automatic t_clear();
      wr(4, 8'hEF);
      rd_chk("R2 clear overflow only", 4, 8'h28);
      wr(4, 8'hF7);
      rd_chk("R2 clear match D", 4, 8'h20);
      wr(4, 8'hFF);
      rd_chk("R2 write ones keeps", 4, 8'h20);
   endtask

   task automatic t_race();
      @(negedge clk);
      reg_addr = 3'd0; reg_wdata = 8'h00; reg_we = 1'b1; ev_match = 8'h02;
      @(negedge clk);
      reg_we = 1'b0; ev_match = '0;
      rd_chk("R3 event beats clear", 0, 8'h02);
   endtask

   task automatic t_enable();
      wr(1, 8'h01);
      chk("R5 unenabled flag no req", int'(irq_req[0]), 0);
      rd_chk("R7 req bit low", 2, 8'h00);
      wr(1, 8'h02);
      chk("R5 enabled flag req", int'(irq_req[0]), 1);
      rd_chk("R7 req bit reads 1", 2, 8'h08);
      rd_chk("R4 enable readback", 1, 8'h02);
      wr(5, 8'hFF);
      rd_chk("R4 enable upper bits zero", 5, 8'h1F);
      wr(5, 8'h10);
      chk("R4 shared enable gates underflow", int'(irq_req[1]), 1);
      wr(5, 8'h0F);
      chk("R4 no shared enable no req", int'(irq_req[1]), 0);
   endtask

   task automatic t_hold();
      wr(1, 8'h03);
      pulse(8'h01, 2'b00, 2'b00);
      rd_chk("R6 two flags set", 0, 8'h03);
      wr(0, 8'hFD);
      chk("R6 req holds with A left", int'(irq_req[0]), 1);
      wr(1, 8'h02);
      chk("R5 req drops when enable removed", int'(irq_req[0]), 0);
      wr(1, 8'h01);
      chk("R6 req back with A enabled", int'(irq_req[0]), 1);
      wr(0, 8'hFE);
      chk("R5 req drops at once", int'(irq_req[0]), 0);
   endtask

   task automatic t_ctrl();
      wr(2, 8'h0D);
      rd_chk("R7 req bit not writable", 2, 8'h05);
      wr(2, 8'hF3);
      rd_chk("R7 upper ctrl bits zero", 2, 8'h03);
   endtask

   task automatic t_deliver();
      wr(2, 8'h05);
      pulse(8'h01, 2'b00, 2'b00);
      gie = 1'b0; cpu_ipl = 3'd0; #1;
      chk("R8 gie off blocks", int'(irq_out), 0);
      gie = 1'b1; cpu_ipl = 3'd5; #1;
      chk("R8 equal level blocks", int'(irq_out), 0);
      cpu_ipl = 3'd4; #1;
      chk("R8 delivered", int'(irq_out), 1);
      chk("R8 channel", int'(irq_ch), 0);
      chk("R8 level", int'(irq_lvl), 5);
      repeat (3) @(negedge clk);
      rd_chk("R2 delivery keeps flag", 0, 8'h01);
      cpu_ipl = 3'd0;
      wr(2, 8'h00);
      chk("R8 level zero never delivers", int'(irq_out), 0);
   endtask

   task automatic t_arb();
      wr(2, 8'h03);
      wr(5, 8'h10);
      wr(6, 8'h06);
      cpu_ipl = 3'd1; #1;
      chk("R9 higher level wins", int'(irq_ch), 1);
      chk("R9 winner level", int'(irq_lvl), 6);
      wr(6, 8'h03);
      chk("R9 tie to channel 0", int'(irq_ch), 0);
      chk("R9 tie delivered", int'(irq_out), 1);
      wr(2, 8'h01);
      chk("R9 ch0 below ipl ch1 wins", int'(irq_ch), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set();
      t_clear();
      t_race();
      t_enable();
      t_hold();
      t_ctrl();
      t_deliver();
      t_arb();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule